// File: doc/BRIEF.md
# Scan clock and channel sequencer

This block sits in front of a four-channel sampling converter and decides when a sample is taken and which input it comes from. A host writes one configuration word through a synchronous write port. The block picks one of up to four master clock enables and divides that enable by 1, 2, 4 or 8. It then issues a one-cycle scan strobe on each resulting period. The strobe carries the index of the channel to convert, and the block steps through a scan group of one channel, a pair of channels, or all four inputs.

The same word sets two pair-enable bits and two power-down bits. A channel whose pair is disabled is internally grounded, and a flag beside each strobe marks such samples so that they read as zero. When power-down is released, an offset-calibration timer runs for a fixed number of cycles. No scan starts until that timer ends. While powered down or calibrating, the divider and the channel pointer are held at their start values, so the first scan afterwards begins on a clean period.

Top module: `acq_scan_seq`

## Requirements
- R1: After reset, the scan strobe and the calibration flag are 0. Both power-down outputs are 1, meaning bit 11 and bit 12 of the configuration start set.
- R2: A word on `cfg_wdata` with `cfg_we` high is stored at that clock edge. No scan strobe results from an edge at which a write occurs.
- R3: Configuration bits [4:3] select which bit of `mclk_en` is the period source. Select values at or above `NUM_MCLK` give no pulses. Enables on the bits that are not selected have no effect.
- R4: Configuration bits [6:5] hold a shift n. A scan strobe follows every 2^n-th pulse of the selected enable, one cycle after that pulse.
- R5: A write that changes bits [6:3] restarts the pulse count. The next strobe then comes on the 2^n-th selected pulse after the write.
- R6: Configuration bits [2:0] choose the scan group. 1xx scans channel xx alone, 010 scans channels 0 and 1, 011 scans channels 2 and 3, 001 scans channels 0 to 3, and 000 produces no strobes.
- R7: Within a group, channels follow in ascending order and wrap to the group's first channel. A write that changes bits [2:0] restarts at the first channel of the new group.
- R8: Bit 7 enables channels 0 and 1 and bit 8 enables channels 2 and 3. `scan_grounded` is high with a strobe whose channel belongs to a disabled pair.
- R9: Bit 11 (analog) and bit 12 (digital) drive `pd_analog` and `pd_digital`. While either bit is set, no strobe occurs and the count and channel pointer are held reset.
- R10: A write that clears both power-down bits while either was set raises `cal_busy` for exactly `CAL_CYCLES` cycles. No strobe occurs while `cal_busy` is high.
- R11: Each strobe lasts one cycle. `scan_chan` and `scan_grounded` are valid while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 13 | Configuration word |
| mclk_en | input | NUM_MCLK | Master clock enable pulses, one per source |
| scan_strobe | output | 1 | One-cycle conversion request |
| scan_chan | output | 2 | Channel sampled with the strobe |
| scan_grounded | output | 1 | Strobed channel belongs to a disabled pair |
| cal_busy | output | 1 | Offset calibration in progress |
| pd_analog | output | 1 | Analog section powered down |
| pd_digital | output | 1 | Digital section powered down |

## Verification
The hardest case to reach is the interplay of a write with a partly filled divider count. A write that alters the clock fields must discard the count, while a write that keeps them must not. A write held high every cycle must suppress strobes entirely. The bench drives four free-running enables with coprime periods, so the count sits at varied values when writes land. It then issues writes that change only the select, only the group, or nothing at all, as well as a held write burst, and a behavioural model tracks every strobe and channel. Power-down is set again in mid-scan and released, which checks that the calibration window repeats and that scanning restarts from the group's first channel.

// File: rtl/acq_scan_pkg.sv
package acq_scan_pkg;
   localparam int CFG_W      = 13;
   localparam int MODE_LSB   = 0;
   localparam int MODE_W     = 3;
   localparam int SEL_LSB    = 3;
   localparam int SEL_W      = 2;
   localparam int SHIFT_LSB  = 5;
   localparam int SHIFT_W    = 2;
   localparam int EN_LO_BIT  = 7;
   localparam int EN_HI_BIT  = 8;
   localparam int PD_ANA_BIT = 11;
   localparam int PD_DIG_BIT = 12;
   localparam int CHAN_W     = 2;

   typedef logic [MODE_W-1:0] mode_t;
   typedef logic [CHAN_W-1:0] chan_t;

   // first channel of the group chosen by a mode code
   function automatic chan_t grp_first(input mode_t m);
      if (m[2])          return m[1:0];
      else if (m == 3'b011) return chan_t'(2);
      else               return chan_t'(0);
   endfunction

   // last channel of the group chosen by a mode code
   function automatic chan_t grp_last(input mode_t m);
      if (m[2])          return m[1:0];
      else if (m == 3'b010) return chan_t'(1);
      else               return chan_t'(3);
   endfunction

   function automatic logic grp_valid(input mode_t m);
      return m != 3'b000;
   endfunction
endpackage

// File: rtl/acq_clk_div.sv
module acq_clk_div #(
   parameter int NUM_MCLK = 4,
   parameter int SEL_W    = 2,
   parameter int SHIFT_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                adv,
   input  logic [SEL_W-1:0]    sel,
   input  logic [SHIFT_W-1:0]  shift,
   input  logic [NUM_MCLK-1:0] mclk_en,
   output logic                tick
);
   localparam int SRC_N     = 1 << SEL_W;
   localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
   localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

   logic [SRC_N-1:0] src_vec;
   logic             pulse;
   logic [CNT_W-1:0] cnt, lim;

   generate
      if (NUM_MCLK > SRC_N || NUM_MCLK < 1) begin : g_bad
         $error("acq_clk_div: NUM_MCLK out of range for select width");
      end
      if (NUM_MCLK < SRC_N) begin : g_pad
         assign src_vec = {{(SRC_N-NUM_MCLK){1'b0}}, mclk_en};
      end else begin : g_full
         assign src_vec = mclk_en;
      end
   endgenerate

   assign pulse = src_vec[sel];

   always_comb begin
      lim = '0;
      for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(shift));
   end

   assign tick = adv && pulse && (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)        cnt <= '0;
      else if (adv && pulse)    cnt <= (cnt == lim) ? '0 : cnt + CNT_W'(1);
   end
endmodule

// File: rtl/acq_chan_step.sv
module acq_chan_step
   import acq_scan_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  restart,
   input  mode_t restart_mode,
   input  logic  step,
   input  mode_t mode,
   output chan_t ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (restart) ptr <= grp_first(restart_mode);
      else if (step)    ptr <= (ptr == grp_last(mode)) ? grp_first(mode) : ptr + chan_t'(1);
   end
endmodule

// File: rtl/acq_cal_timer.sv
module acq_cal_timer #(
   parameter int CAL_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic kill,
   output logic busy
);
   localparam int CW = $clog2(CAL_CYCLES + 1);

   logic [CW-1:0] cnt;

   generate
      if (CAL_CYCLES < 1) begin : g_bad
         $error("acq_cal_timer: CAL_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || kill)   cnt <= '0;
      else if (start)       cnt <= CW'(CAL_CYCLES);
      else if (cnt != '0)   cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
   import acq_scan_pkg::*;
#(
   parameter int NUM_MCLK   = 4,
   parameter int CAL_CYCLES = 1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic [NUM_MCLK-1:0] mclk_en,
   output logic                scan_strobe,
   output logic [CHAN_W-1:0]   scan_chan,
   output logic                scan_grounded,
   output logic                cal_busy,
   output logic                pd_analog,
   output logic                pd_digital
);
   mode_t              mode_q, w_mode;
   logic [SEL_W-1:0]   sel_q, w_sel;
   logic [SHIFT_W-1:0] shift_q, w_shift;
   logic [1:0]         en_q;
   logic               pda_q, pdd_q;
   logic               unused_cfg_bits;

   assign w_mode  = cfg_wdata[MODE_LSB +: MODE_W];
   assign w_sel   = cfg_wdata[SEL_LSB +: SEL_W];
   assign w_shift = cfg_wdata[SHIFT_LSB +: SHIFT_W];
   assign unused_cfg_bits = &{1'b0, cfg_wdata[10:9]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         sel_q   <= '0;
         shift_q <= '0;
         en_q    <= '0;
         pda_q   <= 1'b1;
         pdd_q   <= 1'b1;
      end else if (cfg_we) begin
         mode_q  <= w_mode;
         sel_q   <= w_sel;
         shift_q <= w_shift;
         en_q    <= {cfg_wdata[EN_HI_BIT], cfg_wdata[EN_LO_BIT]};
         pda_q   <= cfg_wdata[PD_ANA_BIT];
         pdd_q   <= cfg_wdata[PD_DIG_BIT];
      end
   end

   logic powered, run, clk_change, mode_change, tick, step;
   chan_t ptr;

   assign powered     = !pda_q && !pdd_q;
   assign run         = powered && !cal_busy;
   assign clk_change  = cfg_we && ((w_sel != sel_q) || (w_shift != shift_q));
   assign mode_change = cfg_we && (w_mode != mode_q);

   acq_clk_div #(
      .NUM_MCLK (NUM_MCLK),
      .SEL_W    (SEL_W),
      .SHIFT_W  (SHIFT_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!run || clk_change),
      .adv     (run && !cfg_we),
      .sel     (sel_q),
      .shift   (shift_q),
      .mclk_en (mclk_en),
      .tick    (tick)
   );

   assign step = tick && grp_valid(mode_q);

   acq_chan_step u_step (
      .clk          (clk),
      .rst_n        (rst_n),
      .restart      (!run || mode_change),
      .restart_mode (cfg_we ? w_mode : mode_q),
      .step         (step),
      .mode         (mode_q),
      .ptr          (ptr)
   );

   acq_cal_timer #(
      .CAL_CYCLES (CAL_CYCLES)
   ) u_cal (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cfg_we && !powered && !cfg_wdata[PD_ANA_BIT] && !cfg_wdata[PD_DIG_BIT]),
      .kill  (cfg_we && (cfg_wdata[PD_ANA_BIT] || cfg_wdata[PD_DIG_BIT])),
      .busy  (cal_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_strobe   <= 1'b0;
         scan_chan     <= '0;
         scan_grounded <= 1'b0;
      end else begin
         scan_strobe <= step;
         if (step) begin
            scan_chan     <= ptr;
            scan_grounded <= !en_q[ptr[CHAN_W-1]];
         end
      end
   end

   assign pd_analog  = pda_q;
   assign pd_digital = pdd_q;
endmodule

// File: rtl/acq_scan_sva.sv
module acq_scan_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       scan_strobe,
   input logic [1:0] scan_chan,
   input logic       scan_grounded,
   input logic       cal_busy,
   input logic       pd_analog,
   input logic       pd_digital,
   input logic [2:0] mode,
   input logic [1:0] en_pair
);
   a_r9_no_strobe_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_analog || pd_digital) |-> !scan_strobe);

   a_r10_no_strobe_calibrating: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> !scan_strobe);

   a_r10_cal_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> (!pd_analog && !pd_digital && $past(pd_analog || pd_digital)));

   a_r6_idle_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
      scan_strobe |-> (mode != 3'b000));

   a_r6_chan_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      scan_strobe |-> ((mode[2] && scan_chan == mode[1:0]) ||
                       (mode == 3'b010 && scan_chan < 2'd2) ||
                       (mode == 3'b011 && scan_chan >= 2'd2) ||
                       (mode == 3'b001)));

   a_r8_ground_flag: assert property (@(posedge clk) disable iff (!rst_n)
      scan_strobe |-> (scan_grounded == !en_pair[scan_chan[1]]));
endmodule

bind acq_scan_seq acq_scan_sva u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .scan_strobe   (scan_strobe),
   .scan_chan     (scan_chan),
   .scan_grounded (scan_grounded),
   .cal_busy      (cal_busy),
   .pd_analog     (pd_analog),
   .pd_digital    (pd_digital),
   .mode          (mode_q),
   .en_pair       (en_q)
);

// File: tb/acq_scan_seq_tb.sv
`timescale 1ns/1ps
module acq_scan_seq_tb;
   localparam int NM    = 4;
   localparam int CAL_T = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [12:0] cfg_wdata = '0;
   logic [NM-1:0] mclk_en = '0;
   logic        scan_strobe, scan_grounded, cal_busy, pd_analog, pd_digital;
   logic [1:0]  scan_chan;

   always #2.5 clk = ~clk;

   acq_scan_seq #(.NUM_MCLK(NM), .CAL_CYCLES(CAL_T)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .mclk_en(mclk_en), .scan_strobe(scan_strobe), .scan_chan(scan_chan),
      .scan_grounded(scan_grounded), .cal_busy(cal_busy),
      .pd_analog(pd_analog), .pd_digital(pd_digital)
   );

   int n_chk = 0, n_err = 0;
   int dut_cnt = 0, mdl_cnt = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference
   logic [12:0] m_cfg;
   int m_cnt, m_idx, m_cal;
   int grp[$];
   bit exp_strobe, exp_gnd;
   int exp_chan;

   function automatic void build_grp(input logic [2:0] md);
      grp = {};
      if (md[2]) grp.push_back(int'(md[1:0]));
      else if (md == 3'b010) begin grp.push_back(0); grp.push_back(1); end
      else if (md == 3'b011) begin grp.push_back(2); grp.push_back(3); end
      else if (md == 3'b001) for (int c = 0; c < 4; c++) grp.push_back(c);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 13'h1800; m_cnt = 0; m_idx = 0; m_cal = 0; exp_strobe = 0;
      end else begin
         bit pwr, run, p;
         int sel, lim;
         pwr = !m_cfg[11] && !m_cfg[12];
         run = pwr && (m_cal == 0);
         exp_strobe = 0;
         if (cfg_we) begin
            if (cfg_wdata[6:3] != m_cfg[6:3]) m_cnt = 0;
            if (cfg_wdata[2:0] != m_cfg[2:0]) m_idx = 0;
            if (!run) begin m_cnt = 0; m_idx = 0; end
            if (cfg_wdata[12:11] == 2'b00 && !pwr) m_cal = CAL_T;
            else if (cfg_wdata[12:11] != 2'b00) m_cal = 0;
            else if (m_cal > 0) m_cal--;
            m_cfg = cfg_wdata;
         end else if (!run) begin
            m_cnt = 0; m_idx = 0;
            if (m_cal > 0) m_cal--;
         end else begin
            sel = int'(m_cfg[4:3]);
            p = (sel < NM) ? mclk_en[sel] : 1'b0;
            lim = (1 << int'(m_cfg[6:5])) - 1;
            if (p) begin
               if (m_cnt == lim) begin
                  m_cnt = 0;
                  build_grp(m_cfg[2:0]);
                  if (grp.size() > 0) begin
                     exp_strobe = 1;
                     exp_chan = grp[m_idx];
                     exp_gnd = (exp_chan < 2) ? !m_cfg[7] : !m_cfg[8];
                     m_idx = (m_idx + 1) % grp.size();
                  end
               end else m_cnt++;
            end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (scan_strobe) dut_cnt++;
         if (exp_strobe) mdl_cnt++;
         chk(scan_strobe == exp_strobe, "R11", "strobe", scan_strobe, exp_strobe);
         if (exp_strobe && scan_strobe) begin
            chk(int'(scan_chan) == exp_chan, "R7", "channel", scan_chan, exp_chan);
            chk(scan_grounded == exp_gnd, "R8", "grounded", scan_grounded, exp_gnd);
         end
         chk(cal_busy == (m_cal != 0), "R10", "cal_busy", cal_busy, m_cal != 0);
         chk(pd_analog == m_cfg[11] && pd_digital == m_cfg[12], "R9", "power-down",
             {pd_digital, pd_analog}, m_cfg[12:11]);
      end
   end

   // master clock enables with coprime periods
   initial begin
      int per[4] = '{3, 4, 5, 7};
      int cnt[4] = '{0, 0, 0, 0};
      forever begin
         @(negedge clk);
         for (int i = 0; i < NM; i++) begin
            cnt[i] = (cnt[i] + 1) % per[i];
            mclk_en[i] = (cnt[i] == 0);
         end
      end
   end

   task automatic tick_n(input int n);
      repeat (n) begin @(negedge clk); #0.2; end
   endtask

   task automatic wr(input logic [12:0] v);
      cfg_wdata = v; cfg_we = 1'b1; tick_n(1); cfg_we = 1'b0;
   endtask

   function automatic logic [12:0] mk(input bit pda, input bit pdd, input bit en_hi,
                                      input bit en_lo, input int sh, input int sel, input int md);
      logic [12:0] v = '0;
      v[2:0] = md[2:0]; v[4:3] = sel[1:0]; v[6:5] = sh[1:0];
      v[7] = en_lo; v[8] = en_hi; v[11] = pda; v[12] = pdd;
      return v;
   endfunction

   task automatic phase(input int n, input string req, input bit expect_some);
      int d0, m0;
      d0 = dut_cnt; m0 = mdl_cnt;
      tick_n(n);
      chk(dut_cnt - d0 == mdl_cnt - m0, req, "strobe count in phase", dut_cnt - d0, mdl_cnt - m0);
      if (expect_some) chk(dut_cnt - d0 > 0, req, "strobes present", dut_cnt - d0, 1);
      else             chk(dut_cnt - d0 == 0, req, "no strobes", dut_cnt - d0, 0);
   endtask

   task automatic finish_run;
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int busy_len, d0;
      tick_n(3);
      // R1: reset state
      chk(scan_strobe == 0, "R1", "strobe at reset", scan_strobe, 0);
      chk(pd_analog && pd_digital, "R1", "power-down at reset", {pd_digital, pd_analog}, 3);
      chk(cal_busy == 0, "R1", "cal_busy at reset", cal_busy, 0);
      rst_n = 1'b1;
      tick_n(5);
      phase(10, "R9", 0);

      // R10: release power-down, calibration window
      wr(mk(0, 0, 1, 1, 0, 0, 3'b001));
      busy_len = 0;
      while (cal_busy && busy_len < 1000) begin busy_len++; tick_n(1); end
      chk(busy_len == CAL_T, "R10", "calibration length", busy_len, CAL_T);

      phase(150, "R6", 1);                               // all four, sel0, /1
      wr(mk(0, 0, 1, 1, 2, 0, 3'b001)); phase(200, "R4", 1);  // /4, R5 restart
      wr(mk(0, 0, 1, 0, 1, 2, 3'b010)); phase(200, "R8", 1);  // pair 0/1 grounded
      wr(mk(0, 0, 0, 1, 1, 2, 3'b011)); phase(150, "R8", 1);  // pair 2/3 grounded
      wr(mk(0, 0, 1, 1, 3, 3, 3'b110)); phase(300, "R3", 1);  // channel 2 only, sel3 /8
      wr(mk(0, 0, 1, 1, 3, 1, 3'b110)); phase(200, "R5", 1);  // select change only
      wr(mk(0, 0, 1, 1, 0, 1, 3'b000)); phase(150, "R6", 0);  // idle mode
      wr(mk(0, 0, 1, 1, 0, 1, 3'b101)); phase(60, "R6", 1);   // channel 1 only
      wr(mk(0, 0, 1, 1, 1, 1, 3'b001)); phase(100, "R7", 1);  // all four again

      // R2: writes held every cycle suppress strobes
      cfg_wdata = mk(0, 0, 1, 1, 0, 0, 3'b001); cfg_we = 1'b1;
      d0 = dut_cnt;
      tick_n(40);
      chk(dut_cnt == d0, "R2", "strobes under held write", dut_cnt - d0, 0);
      cfg_we = 1'b0;
      phase(80, "R2", 1);

      // R9: analog power-down in mid-scan, then release again
      wr(mk(1, 0, 1, 1, 0, 0, 3'b001)); phase(100, "R9", 0);
      chk(pd_analog == 1 && cal_busy == 0, "R9", "analog down, no cal", {cal_busy, pd_analog}, 1);
      wr(mk(0, 0, 1, 1, 0, 0, 3'b001));
      busy_len = 0;
      while (cal_busy && busy_len < 1000) begin busy_len++; tick_n(1); end
      chk(busy_len == CAL_T, "R10", "second calibration length", busy_len, CAL_T);
      phase(120, "R7", 1);

      wr(mk(0, 1, 1, 1, 0, 0, 3'b001)); phase(60, "R9", 0);
      finish_run();
   end
endmodule